// File: doc/BRIEF.md
# Flash Command Interface and Program Status

This block is a device-side model of a flash card's command decoder and its write-sequencer status register. Every bus write is taken either as a command byte or, right after a program-setup command, as the address and data to program. Reads return either the contents of a small internal array or the status register, depending on the current read mode.

A program operation occupies a programmable number of clock cycles. During that time the ready bit is low and further bus writes are dropped. At the end, the array word becomes `old AND data`. Two sticky error bits record a failure: one for a bad supply, one for a word that does not read back as requested. These bits stay set across later programs until a clear command arrives. A supply failure also locks out further programs until that clear. The supply-good flag is an input.

Top module: `flashc_top`

## Requirements
- R1: After reset (or a reset in the middle of a program) the block is in array-read mode, the status word reads 80H, and every array word reads FFH.
- R2: A write of 40H arms a program. The next write programs `addr_i` with `wdata_i`. Reads while armed, and after that data write, return the status word.
- R3: Status bit 7 reads 0 for exactly BUSY_CYCLES clock cycles after the data write, then reads 1. Bus writes made while bit 7 is 0 are ignored.
- R4: If `vpp_ok_i` is low on the data write, status bit 3 is set when the operation ends, and the array word is left unchanged.
- R5: A program stores `old AND data`. When that result differs from the requested data, status bit 4 is set. Bit 4 stays set across later programs until a clear.
- R6: A write of FFH (when not armed and not busy) selects array-read mode.
- R7: While status bit 3 is set, a program leaves the array unchanged and keeps bit 3 set, even with `vpp_ok_i` high.
- R8: A write of 50H clears status bits 3 and 4 and leaves the read mode unchanged.
- R9: Any other command byte written outside the armed state is ignored, and the read mode is kept.
- R10: Status bits other than 7, 4 and 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe, one write per cycle it is high |
| addr_i | input | ADDR_W | Word address for reads and program data writes |
| wdata_i | input | DATA_W | Command byte or program data |
| vpp_ok_i | input | 1 | Programming supply good |
| rd_data_o | output | DATA_W | Array word or status word, combinational from address and mode |

## Verification
The bench builds the block with BUSY_CYCLES = 3, ADDR_W = 4 and DATA_W = 8. The short busy window makes it practical to check every cycle of a program. It also lets a write land inside the busy window, so the bench can test that such a write is dropped. The 16-word array is large enough to program several distinct words. One word is programmed twice, which produces a bit-clearing mismatch, and others are used for the supply lockout, the clear that follows it, and a reset during a program.

// File: rtl/flashc_pkg.sv
package flashc_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_ARMED  = 2'd2
  } mode_e;

  localparam logic [7:0] CMD_PROG  = 8'h40;
  localparam logic [7:0] CMD_CLEAR = 8'h50;
  localparam logic [7:0] CMD_ARRAY = 8'hFF;

  localparam int unsigned SB_READY = 7;
  localparam int unsigned SB_WERR  = 4;
  localparam int unsigned SB_VPP   = 3;
endpackage

// File: rtl/flashc_decode.sv
module flashc_decode
  import flashc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  output mode_e             mode_o,
  output logic              start_o,
  output logic              clear_o
);
  mode_e       mode_q, mode_d;
  logic        wr_ok;
  logic [7:0]  cmd;

  assign wr_ok = wr_en_i && !busy_i;
  assign cmd   = wdata_i[7:0];

  always_comb begin
    mode_d  = mode_q;
    start_o = 1'b0;
    clear_o = 1'b0;
    if (wr_ok) begin
      if (mode_q == MODE_ARMED) begin
        start_o = 1'b1;
        mode_d  = MODE_STATUS;
      end else begin
        unique case (cmd)
          CMD_PROG:  mode_d  = MODE_ARMED;
          CMD_ARRAY: mode_d  = MODE_ARRAY;
          CMD_CLEAR: clear_o = 1'b1;
          default:   mode_d  = mode_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_ARRAY;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  p_data_to_status_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && mode_q == MODE_ARMED) |=> (mode_q == MODE_STATUS));
  p_ffh_array_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && mode_q != MODE_ARMED && cmd == CMD_ARRAY) |=> (mode_q == MODE_ARRAY));
  p_unknown_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && mode_q != MODE_ARMED && cmd != CMD_PROG && cmd != CMD_ARRAY)
      |=> $stable(mode_q));
  p_busy_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(mode_q));
endmodule

// File: rtl/flashc_array.sv
module flashc_array #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [ADDR_W-1:0] pg_addr_i,
  output logic [DATA_W-1:0] pg_old_o,
  input  logic              pg_en_i,
  input  logic [DATA_W-1:0] pg_data_i
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[g] <= '1;
      else if (pg_en_i && pg_addr_i == ADDR_W'(g))
        mem_q[g] <= mem_q[g] & pg_data_i;  // cells only go 1 -> 0
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign pg_old_o  = mem_q[pg_addr_i];

  p_only_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_en_i |=> ((mem_q[$past(pg_addr_i)] & ~$past(pg_old_o)) == '0));
endmodule

// File: rtl/flashc_wsm.sv
module flashc_wsm #(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned BUSY_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              vpp_ok_i,
  input  logic [DATA_W-1:0] old_i,
  output logic [ADDR_W-1:0] pg_addr_o,
  output logic [DATA_W-1:0] pg_data_o,
  output logic              pg_en_o,
  output logic              busy_o,
  output logic              werr_o,
  output logic              vpp_err_o
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              fail_q;
  logic              werr_q, vpp_q;
  logic              finish;

  assign busy_o = (cnt_q != '0);
  assign finish = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      fail_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= CNT_W'(BUSY_CYCLES);
      addr_q <= addr_i;
      data_q <= data_i;
      fail_q <= !vpp_ok_i || vpp_q;  // supply low now, or still locked out
    end else if (busy_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign pg_addr_o = addr_q;
  assign pg_data_o = data_q;
  assign pg_en_o   = finish && !fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      werr_q <= 1'b0;
      vpp_q  <= 1'b0;
    end else if (clear_i) begin
      werr_q <= 1'b0;
      vpp_q  <= 1'b0;
    end else if (finish) begin
      if (fail_q)                            vpp_q  <= 1'b1;
      else if ((old_i & data_q) != data_q)   werr_q <= 1'b1;
    end
  end

  assign werr_o    = werr_q;
  assign vpp_err_o = vpp_q;

  p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  p_werr_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (werr_q && !clear_i) |=> werr_q);
  p_vpp_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpp_q && !clear_i) |=> vpp_q);
  p_vpp_fail_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish && fail_q) |=> (vpp_q && !busy_o));
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !finish) |=> (!werr_q && !vpp_q));
endmodule

// File: rtl/flashc_top.sv
module flashc_top
  import flashc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned BUSY_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              vpp_ok_i,
  output logic [DATA_W-1:0] rd_data_o
);
  mode_e             mode;
  logic              start, clear, busy, werr, vpp_err, pg_en;
  logic [ADDR_W-1:0] pg_addr;
  logic [DATA_W-1:0] pg_data, pg_old, arr_rd, status_w;

  flashc_decode #(.DATA_W(DATA_W)) u_decode (
    .clk_i, .rst_ni, .wr_en_i, .wdata_i,
    .busy_i (busy),
    .mode_o (mode),
    .start_o(start),
    .clear_o(clear)
  );

  flashc_wsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_wsm (
    .clk_i, .rst_ni,
    .start_i  (start),
    .clear_i  (clear),
    .addr_i   (addr_i),
    .data_i   (wdata_i),
    .vpp_ok_i (vpp_ok_i),
    .old_i    (pg_old),
    .pg_addr_o(pg_addr),
    .pg_data_o(pg_data),
    .pg_en_o  (pg_en),
    .busy_o   (busy),
    .werr_o   (werr),
    .vpp_err_o(vpp_err)
  );

  flashc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni,
    .rd_addr_i(addr_i),
    .rd_data_o(arr_rd),
    .pg_addr_i(pg_addr),
    .pg_old_o (pg_old),
    .pg_en_i  (pg_en),
    .pg_data_i(pg_data)
  );

  always_comb begin
    status_w           = '0;
    status_w[SB_READY] = !busy;
    status_w[SB_WERR]  = werr;
    status_w[SB_VPP]   = vpp_err;
  end

  assign rd_data_o = (mode == MODE_ARRAY) ? arr_rd : status_w;

  p_status_reads_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != MODE_ARRAY) |-> ((rd_data_o & ~DATA_W'(8'h98)) == '0));
  p_busy_status_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (mode != MODE_ARRAY));
endmodule

// File: tb/flashc_top_bench.sv
module flashc_top_bench;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned BUSY   = 3;

  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_T = 2'd2;
  localparam int unsigned NV = 57;
  // {op, addr, data/expected, vpp, requirement}
  localparam logic [18:0] VEC [NV] = '{
    {OP_R, 4'h0, 8'hFF, 1'b1, 4'd1},  // R1 array erased
    {OP_R, 4'h3, 8'hFF, 1'b1, 4'd1},
    {OP_W, 4'h0, 8'h40, 1'b1, 4'd2},
    {OP_R, 4'h0, 8'h80, 1'b1, 4'd2},  // R2 armed reads status
    {OP_W, 4'h5, 8'h3C, 1'b1, 4'd2},
    {OP_R, 4'h0, 8'h00, 1'b1, 4'd3},  // R3 busy
    {OP_T, 4'h0, 8'h00, 1'b1, 4'd3},
    {OP_R, 4'h0, 8'h80, 1'b1, 4'd3},
    {OP_W, 4'h0, 8'hFF, 1'b1, 4'd6},
    {OP_R, 4'h5, 8'h3C, 1'b1, 4'd2},  // R2 programmed
    {OP_R, 4'h4, 8'hFF, 1'b1, 4'd6},  // R6 array mode
    {OP_W, 4'h0, 8'h40, 1'b1, 4'd5},
    {OP_W, 4'h5, 8'h0F, 1'b1, 4'd5},
    {OP_T, 4'h0, 8'h00, 1'b1, 4'd5},
    {OP_R, 4'h0, 8'h90, 1'b1, 4'd5},  // R5 mismatch 3C&0F
    {OP_W, 4'h0, 8'hFF, 1'b1, 4'd5},
    {OP_R, 4'h5, 8'h0C, 1'b1, 4'd5},  // R5 old AND data
    {OP_W, 4'h0, 8'h40, 1'b1, 4'd5},
    {OP_W, 4'h6, 8'h55, 1'b1, 4'd5},
    {OP_T, 4'h0, 8'h00, 1'b1, 4'd5},
    {OP_R, 4'h0, 8'h90, 1'b1, 4'd5},  // R5 sticky
    {OP_W, 4'h0, 8'hFF, 1'b1, 4'd5},
    {OP_R, 4'h6, 8'h55, 1'b1, 4'd5},
    {OP_W, 4'h0, 8'h50, 1'b1, 4'd8},
    {OP_R, 4'h6, 8'h55, 1'b1, 4'd8},  // R8 mode kept
    {OP_W, 4'h0, 8'h70, 1'b1, 4'd9},
    {OP_R, 4'h6, 8'h55, 1'b1, 4'd9},  // R9 ignored
    {OP_W, 4'h0, 8'h40, 1'b1, 4'd8},
    {OP_R, 4'h0, 8'h80, 1'b1, 4'd8},  // R8 bit4 cleared
    {OP_W, 4'h7, 8'h11, 1'b0, 4'd4},
    {OP_T, 4'h0, 8'h00, 1'b1, 4'd4},
    {OP_R, 4'h0, 8'h88, 1'b1, 4'd4},  // R4 bit3
    {OP_W, 4'h0, 8'hFF, 1'b1, 4'd4},
    {OP_R, 4'h7, 8'hFF, 1'b1, 4'd4},  // R4 not programmed
    {OP_W, 4'h0, 8'h40, 1'b1, 4'd7},
    {OP_W, 4'h7, 8'h22, 1'b1, 4'd7},
    {OP_T, 4'h0, 8'h00, 1'b1, 4'd7},
    {OP_R, 4'h0, 8'h88, 1'b1, 4'd7},  // R7 locked
    {OP_W, 4'h0, 8'hFF, 1'b1, 4'd7},
    {OP_R, 4'h7, 8'hFF, 1'b1, 4'd7},
    {OP_W, 4'h0, 8'h50, 1'b1, 4'd8},
    {OP_W, 4'h0, 8'h40, 1'b1, 4'd8},
    {OP_W, 4'h7, 8'h22, 1'b1, 4'd8},
    {OP_T, 4'h0, 8'h00, 1'b1, 4'd8},
    {OP_R, 4'h0, 8'h80, 1'b1, 4'd8},  // R8 bit3 cleared
    {OP_W, 4'h0, 8'hFF, 1'b1, 4'd7},
    {OP_R, 4'h7, 8'h22, 1'b1, 4'd7},  // R7 unlocked
    {OP_W, 4'h0, 8'h40, 1'b1, 4'd3},
    {OP_W, 4'h8, 8'hA5, 1'b1, 4'd3},
    {OP_W, 4'h0, 8'hFF, 1'b1, 4'd3},  // dropped while busy
    {OP_R, 4'h8, 8'h00, 1'b1, 4'd3},
    {OP_T, 4'h0, 8'h00, 1'b1, 4'd3},
    {OP_R, 4'h8, 8'h80, 1'b1, 4'd3},  // R3 still status mode
    {OP_W, 4'h0, 8'h70, 1'b1, 4'd9},
    {OP_R, 4'h8, 8'h80, 1'b1, 4'd9},  // R9 status mode kept
    {OP_W, 4'h0, 8'hFF, 1'b1, 4'd10},
    {OP_R, 4'h8, 8'hA5, 1'b1, 4'd10}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic              vpp_ok = 1'b1;
  logic [DATA_W-1:0] rd_data;
  int                n_chk = 0;
  int                n_fail = 0;
  logic              done = 1'b0;

  always #2 clk = ~clk;

  flashc_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY)) u_flashc_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .vpp_ok_i(vpp_ok), .rd_data_o(rd_data)
  );

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input logic v);
    wr_en = 1'b1; addr = a; wdata = d; vpp_ok = v;
    @(negedge clk);
    wr_en = 1'b0; vpp_ok = 1'b1;
  endtask

  task automatic check_rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                          input int req);
    addr = a;
    #1;
    n_chk++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL R%0d addr %0h: got %02h expected %02h", req, a, rd_data, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][18:17];
      case (op)
        OP_W: do_write(VEC[i][16:13], VEC[i][12:5], VEC[i][4]);
        OP_R: check_rd(VEC[i][16:13], VEC[i][12:5], int'(VEC[i][3:0]));
        default: repeat (BUSY) @(negedge clk);
      endcase
    end

    // R3: exact busy window, cycle by cycle
    do_write(4'h0, 8'h40, 1'b1);
    do_write(4'h2, 8'hF0, 1'b1);
    for (int k = 0; k < BUSY; k++) begin
      check_rd(4'h2, 8'h00, 3);  // R3 busy cycle
      @(negedge clk);
    end
    check_rd(4'h2, 8'h80, 3);    // R3 ready after BUSY cycles
    do_write(4'h0, 8'hFF, 1'b1);
    check_rd(4'h2, 8'hF0, 2);

    // R1: reset during a program
    do_write(4'h0, 8'h40, 1'b1);
    do_write(4'h9, 8'h00, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_rd(4'h9, 8'hFF, 1);    // R1 array mode, erased
    check_rd(4'h5, 8'hFF, 1);
    do_write(4'h0, 8'h40, 1'b1);
    check_rd(4'h0, 8'h80, 1);    // R1 status 80H

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule